// File: doc/BRIEF.md
# Windowed Limit Fault Status Register

The block watches seven 8-bit measurement channels: four supply voltages and three remote temperature zones. Each channel is compared against its own low and high limit whenever a new set of measurements is strobed in. A value at or below the low limit, or above the high limit, counts as a fault for that channel and sets a sticky bit in one status byte. The remote diode sensors of zones 1 and 3 can also report an open or shorted diode, and that report sets the same bit as the zone's limit fault. An external summary of secondary status sets the top bit.

Software reads the byte through a read strobe. A read clears a bit only when the fault behind it has gone away. A bit whose fault is still present, or whose fault is detected again in the same cycle as the read, stays set. There is no write path into the byte. The limit registers, the converter sequencing and the routing of any interrupt pin belong to other blocks.

Top module: `lim_fault_stat`

## Requirements
- R1: On a strobed measurement, channel k is in fault when its value, taken as unsigned, is less than or equal to its low limit or strictly greater than its high limit. A value equal to the high limit is not a fault. The status bit shows the fault one clock after the strobe.
- R2: Channel values and limits are compared only in cycles where meas_vld_i is 1. Values presented while it is 0 neither set bits nor change the fault state that a later read tests.
- R3: Status bit k (k = 0..6) belongs to channel k. The order is: bit 0 = 2.5 V, bit 1 = processor core supply, bit 2 = 3.3 V, bit 3 = 5 V, bit 4 = zone 1, bit 5 = zone 2, bit 6 = zone 3. Bit 7 is the secondary error bit.
- R4: diode_flt_i[0] = 1 sets bit 4 and diode_flt_i[1] = 1 sets bit 6 one clock later, with or without a strobe.
- R5: sec_err_i = 1 sets bit 7 one clock later. That bit is sticky and is cleared on read like the others.
- R6: A set bit stays set while no read occurs, even after its fault has gone away.
- R7: A cycle with stat_rd_i = 1 clears every bit whose fault is no longer present. For a limit bit, "present" means the most recent strobed comparison found a fault. For bits 4 and 6 it also means the diode input is 1. For bit 7 it means sec_err_i is 1.
- R8: A read leaves a bit set while its fault is still present.
- R9: A fault detected in the same cycle as a read is kept. Setting a bit takes priority over clearing it.
- R10: Faults on several channels at once set all their bits together, and one read returns all of them.
- R11: While reset is active, and after it ends with no faults, the status byte is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| meas_vld_i | input | 1 | Strobe: channel values are new this cycle |
| meas_val_i | input | 56 | Channel values, channel k in bits 8k+7:8k |
| lim_lo_i | input | 56 | Low limits, same packing |
| lim_hi_i | input | 56 | High limits, same packing |
| diode_flt_i | input | 2 | Remote diode fault: bit 0 zone 1, bit 1 zone 3 |
| sec_err_i | input | 1 | Secondary status summary |
| stat_rd_i | input | 1 | Read strobe for the status byte |
| stat_o | output | 8 | Status byte |

## Verification
The assertions assume that every input is at a known level on each rising clock edge once reset is released. They also assume the read strobe is a one-cycle qualifier that is not tied to any handshake. Limits may be inverted (low above high); the window rule then simply flags everything. The stimulus changes inputs only just after a clock edge, uses inverted and equal limits together with ordinary windows, and places strobes, reads, diode reports and secondary errors freely in the same cycle. It also uses directed values exactly at each limit.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam int unsigned LFS_NCH     = 7;
  localparam int unsigned LFS_SW      = LFS_NCH + 1;
  localparam int unsigned LFS_ERR_BIT = LFS_NCH;
  localparam int unsigned LFS_Z1_BIT  = 4;
  localparam int unsigned LFS_Z3_BIT  = 6;

  typedef logic [LFS_SW-1:0] lfs_stat_t;

  // place the live (level) fault inputs onto their status positions
  function automatic lfs_stat_t lfs_live_map(input logic [1:0] diode, input logic err);
    lfs_stat_t m;
    m = '0;
    m[LFS_Z1_BIT]  = diode[0];
    m[LFS_Z3_BIT]  = diode[1];
    m[LFS_ERR_BIT] = err;
    return m;
  endfunction

endpackage

// File: rtl/lfs_win_cmp.sv
module lfs_win_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  output logic          flt_o
);

  logic below_or_at;
  logic above;

  always_comb begin
    below_or_at = (val_i <= lo_i);
    above       = (val_i > hi_i);
    flt_o       = below_or_at | above;
  end

endmodule

// File: rtl/lfs_cond_reg.sv
module lfs_cond_reg #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] cond_q;
  logic [W-1:0] cond_d;

  always_comb begin
    cond_d = cond_q;
    if (en_i) cond_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else         cond_q <= cond_d;
  end

  assign q_o = cond_q;

  // R2: without a strobe the remembered comparison result does not move
  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cond_q));

endmodule

// File: rtl/lfs_sticky.sv
module lfs_sticky #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] pres_i,
  input  logic         rd_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic [W-1:0] keep;

  always_comb begin
    keep   = rd_i ? (stat_q & pres_i) : stat_q;
    stat_d = keep | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign q_o = stat_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    // R6: no read, no loss
    a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[b] && !rd_i) |=> stat_q[b]);
    // R7: read with the fault gone and nothing new clears the bit
    a_r7_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !pres_i[b] && !set_i[b]) |=> !stat_q[b]);
    // R8: read with the fault still there keeps the bit
    a_r8_persist_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && stat_q[b] && pres_i[b]) |=> stat_q[b]);
    // R9: set wins over clear
    a_r9_set_beats_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && set_i[b]) |=> stat_q[b]);
    // a bit rises only through a set request
    a_r6_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_q[b] && !set_i[b]) |=> !stat_q[b]);
  end

endmodule

// File: rtl/lim_fault_stat.sv
module lim_fault_stat
  import lfs_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned NCH = LFS_NCH,
  localparam int unsigned SW  = LFS_SW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_vld_i,
  input  logic [NCH*DW-1:0] meas_val_i,
  input  logic [NCH*DW-1:0] lim_lo_i,
  input  logic [NCH*DW-1:0] lim_hi_i,
  input  logic [1:0]        diode_flt_i,
  input  logic              sec_err_i,
  input  logic              stat_rd_i,
  output logic [SW-1:0]     stat_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // per-channel window comparison
  logic [NCH-1:0] cmp_flt;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    lfs_win_cmp #(.DW(DW)) u_cmp (
      .val_i (meas_val_i[k*DW +: DW]),
      .lo_i  (lim_lo_i[k*DW +: DW]),
      .hi_i  (lim_hi_i[k*DW +: DW]),
      .flt_o (cmp_flt[k])
    );
  end

  // latest strobed comparison result
  logic [NCH-1:0] cond_q;

  lfs_cond_reg #(.W(NCH)) u_cond (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .en_i   (meas_vld_i),
    .d_i    (cmp_flt),
    .q_o    (cond_q)
  );

  // set and present vectors
  lfs_stat_t live;
  lfs_stat_t set_vec;
  lfs_stat_t pres_vec;

  always_comb begin
    live     = lfs_live_map(diode_flt_i, sec_err_i);
    set_vec  = live;
    pres_vec = live;
    if (meas_vld_i) set_vec[NCH-1:0] = set_vec[NCH-1:0] | cmp_flt;
    pres_vec[NCH-1:0] = pres_vec[NCH-1:0] | cond_q;
  end

  lfs_sticky #(.W(SW)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .set_i  (set_vec),
    .pres_i (pres_vec),
    .rd_i   (stat_rd_i),
    .q_o    (stat_o)
  );

  // R1, R3: a strobed fault on channel k appears on bit k
  for (genvar k = 0; k < NCH; k++) begin : g_a
    a_r1_fault_sets_bit: assert property (@(posedge clk_i) disable iff (!rst_int_n)
      (meas_vld_i && cmp_flt[k]) |=> stat_o[k]);
  end

  // R4: diode faults reach the zone bits
  a_r4_zone1_diode: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    diode_flt_i[0] |=> stat_o[LFS_Z1_BIT]);
  a_r4_zone3_diode: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    diode_flt_i[1] |=> stat_o[LFS_Z3_BIT]);

  // R5: secondary error reaches bit 7
  a_r5_sec_err: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    sec_err_i |=> stat_o[LFS_ERR_BIT]);

  // R2: zone 2 has no live source, so without a strobe it cannot rise
  a_r2_no_strobe_no_set: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!meas_vld_i && !stat_o[5]) |=> !stat_o[5]);

endmodule

// File: tb/sim_lim_fault_stat.sv
module sim_lim_fault_stat;
  import lfs_pkg::*;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int NCH   = LFS_NCH;

  logic                   clk = 1'b0;
  logic                   rst_n;
  logic                   vld;
  logic [NCH-1:0][DW-1:0] val;
  logic [NCH-1:0][DW-1:0] lo;
  logic [NCH-1:0][DW-1:0] hi;
  logic [1:0]             diode;
  logic                   err;
  logic                   rd;
  logic [7:0]             stat;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_stat;
  logic [6:0] m_cond;

  always #(CLK_P/2) clk = ~clk;

  lim_fault_stat u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .meas_vld_i  (vld),
    .meas_val_i  (val),
    .lim_lo_i    (lo),
    .lim_hi_i    (hi),
    .diode_flt_i (diode),
    .sec_err_i   (err),
    .stat_rd_i   (rd),
    .stat_o      (stat)
  );

  function automatic logic win_fault(input logic [7:0] v, input logic [7:0] l, input logic [7:0] h);
    return (v <= l) || (v > h);
  endfunction

  function automatic logic [6:0] all_faults();
    logic [6:0] f;
    for (int k = 0; k < NCH; k++) f[k] = win_fault(val[k], lo[k], hi[k]);
    return f;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // one clock: advance the reference, then sample after the edge
  task automatic cyc();
    logic [6:0] f;
    logic [7:0] live, setv, pres, nxt;
    f    = all_faults();
    live = {err, diode[1], 1'b0, diode[0], 4'b0000};
    setv = live | (vld ? {1'b0, f} : 8'h00);
    pres = live | {1'b0, m_cond};
    nxt  = (rd ? (m_stat & pres) : m_stat) | setv;
    @(posedge clk);
    #1;
    m_stat = nxt;
    if (vld) m_cond = f;
  endtask

  task automatic idle();
    vld = 1'b0; rd = 1'b0; diode = 2'b00; err = 1'b0;
  endtask

  task automatic ok_all();
    for (int k = 0; k < NCH; k++) begin
      lo[k] = 8'd10; hi[k] = 8'd240; val[k] = 8'd100;
    end
  endtask

  task automatic clear_all();
    idle(); ok_all(); vld = 1'b1; cyc();
    vld = 1'b0; rd = 1'b1; cyc();
    rd = 1'b0;
    chk("R7 clear", stat, 8'h00);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd4242);
    m_stat = 8'h00; m_cond = 7'h00;
    idle(); ok_all();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 in reset", stat, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R11 after reset", stat, 8'h00);

    // R1 boundaries
    val[0] = 8'd10; vld = 1'b1; cyc(); vld = 1'b0;
    chk("R1 equal low", stat, 8'h01);
    clear_all();
    val[2] = 8'd240; vld = 1'b1; cyc(); vld = 1'b0;
    chk("R1 equal high", stat, 8'h00);
    val[2] = 8'd11; vld = 1'b1; cyc(); vld = 1'b0;
    chk("R1 just above low", stat, 8'h00);
    val[3] = 8'd241; vld = 1'b1; cyc(); vld = 1'b0;
    chk("R1 above high", stat, 8'h08);
    clear_all();

    // R2 no strobe
    val[1] = 8'd0; cyc();
    chk("R2 no strobe", stat, 8'h00);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R2 state untouched", stat, 8'h00);
    ok_all();

    // R3 each channel on its own bit
    for (int k = 0; k < NCH; k++) begin
      val[k] = 8'd250; vld = 1'b1; cyc(); vld = 1'b0;
      chk("R3 layout", stat, 8'(1 << k));
      clear_all();
    end

    // R10 two at once, R6 sticky, R7 read clears
    val[0] = 8'd3; val[5] = 8'd255; vld = 1'b1; cyc();
    chk("R10 two bits", stat, 8'h21);
    ok_all(); cyc(); vld = 1'b0; cyc(); cyc();
    chk("R6 sticky", stat, 8'h21);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R7 read clears", stat, 8'h00);

    // R8 persisting fault survives read
    val[4] = 8'd5; vld = 1'b1; cyc(); vld = 1'b0;
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R8 persist", stat, 8'h10);
    clear_all();

    // R4 diode faults
    diode = 2'b10; cyc(); diode = 2'b00; cyc();
    chk("R4 zone3 sticky", stat, 8'h40);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R4 zone3 cleared", stat, 8'h00);
    diode = 2'b01; cyc(); rd = 1'b1; cyc(); rd = 1'b0;
    chk("R4 zone1 held by live diode", stat, 8'h10);
    diode = 2'b00; rd = 1'b1; cyc(); rd = 1'b0;
    chk("R4 zone1 cleared", stat, 8'h00);

    // R5 secondary error
    err = 1'b1; cyc(); err = 1'b0; cyc();
    chk("R5 err bit", stat, 8'h80);
    rd = 1'b1; cyc(); rd = 1'b0;
    chk("R5 err cleared", stat, 8'h00);

    // R9 set in the read cycle
    val[0] = 8'd10; vld = 1'b1; cyc();
    ok_all(); cyc();
    val[0] = 8'd10; val[6] = 8'd200; hi[6] = 8'd100; rd = 1'b1; cyc();
    rd = 1'b0; vld = 1'b0;
    chk("R9 set beats clear", stat, 8'h41);
    clear_all();
    chk("R9 model sync", stat, m_stat);

    // random mix checked against the reference
    for (int n = 0; n < 4000; n++) begin
      if (n % 256 == 0) begin
        for (int k = 0; k < NCH; k++) begin
          lo[k] = 8'($urandom % 64);
          hi[k] = (n % 1024 == 512) ? 8'($urandom % 64) : 8'(192 + $urandom % 64);
        end
      end
      for (int k = 0; k < NCH; k++) begin
        val[k] = ($urandom % 8 == 0) ? lo[k] : 8'($urandom);
      end
      vld   = ($urandom % 10) < 3;
      rd    = ($urandom % 10) < 2;
      diode = {($urandom % 32) == 0, ($urandom % 32) == 0};
      err   = ($urandom % 32) == 0;
      cyc();
      chk("R7 R8 R9 R10 random", stat, m_stat);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule